// File: doc/BRIEF.md
# Masked Leading/Trailing Zero Counter

This unit takes a 64-bit source word and a 64-bit mask word. It counts the zero bits of the source, but only at positions where the mask is set. A direction input picks where the scan begins. Leading mode starts at the most significant bit and moves down. Trailing mode starts at the least significant bit and moves up. Positions whose mask bit is clear are passed over: they neither add to the count nor end it. The scan ends at the first position where both the mask bit and the source bit are set.

The count is zero-extended into a 64-bit result word. A request is presented for one cycle with `in_valid`. One clock later the answer appears with a one-cycle `out_valid` pulse. The result register keeps that value until the next request is accepted.

Top module: `mask_zero_counter`

## Requirements
- R1: A synchronous active-high `rst` drives `out_valid` to 0 and `out_result` to 0 on the next clock edge, whatever the other inputs are doing.
- R2: A request sampled with `in_valid`=1 on a clock edge produces `out_valid`=1 for exactly the following cycle. `out_valid` is 0 in any cycle that follows an edge where `in_valid` was 0.
- R3: With `in_lead`=0 (trailing), positions are examined in order from bit 0 up to bit 63.
- R4: With `in_lead`=1 (leading), positions are examined in order from bit 63 down to bit 0.
- R5: A position whose mask bit is 0 never changes the count and never ends the scan, whatever its source bit is.
- R6: At a position where the mask bit is 1 and the source bit is 0, the count grows by one. The scan ends at the first examined position where both bits are 1, so a hit at the first examined position gives 0.
- R7: If no position has both bits set, the result equals the number of ones in the mask. An all-zero mask therefore gives 0.
- R8: The result never exceeds 64, and its bits above the count field are always 0. An all-zero source with an all-ones mask gives exactly 64 in either direction.
- R9: While `in_valid` is 0, `out_result` keeps the last computed value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_src | input | 64 | Source word whose zero bits are counted |
| in_mask | input | 64 | Selects which positions take part in the scan |
| in_lead | input | 1 | 1: scan from bit 63 downward; 0: scan from bit 0 upward |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 64 | Zero-extended count, held between requests |

## Verification
The bench uses the default width of 64. The count field is therefore 7 bits wide, and the extreme value 64 can be reached, which checks that the count is not truncated to 6 bits. With this width, bit 63 and bit 0 are the first positions examined in the two directions, so an immediate hit at either end gives a zero result. Long runs of cleared mask bits can surround a hit in either direction. Pseudo-random sparse and dense masks are compared against a bit-serial reference model in both directions.

// File: rtl/mzc_pkg.sv
package mzc_pkg;

    typedef enum logic {
        SCAN_UP   = 1'b0,
        SCAN_DOWN = 1'b1
    } scan_dir_e;

    function automatic int unsigned count_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/mzc_orient.sv
// Puts both operands in trailing order: bit 0 of each output is the
// first position the scan examines.
module mzc_orient #(
    parameter int unsigned W = 64
) (
    input  mzc_pkg::scan_dir_e dir,
    input  logic [W-1:0]       src_i,
    input  logic [W-1:0]       mask_i,
    output logic [W-1:0]       src_o,
    output logic [W-1:0]       mask_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign src_o[g]  = (dir == mzc_pkg::SCAN_DOWN) ? src_i[W-1-g]  : src_i[g];
        assign mask_o[g] = (dir == mzc_pkg::SCAN_DOWN) ? mask_i[W-1-g] : mask_i[g];
    end
endmodule

// File: rtl/mzc_scan.sv
// Counts the mask ones strictly below the lowest position where both the
// source and the mask are set. With no such position, every mask one counts.
module mzc_scan #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = 7
) (
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  mask,
    output logic [CW-1:0] count
);
    logic [W-1:0] hit;
    logic [W-1:0] first_hit;
    logic [W-1:0] before_hit;
    logic [W-1:0] live;

    always_comb begin
        hit        = src & mask;
        first_hit  = hit & (~hit + W'(1));
        before_hit = first_hit - W'(1);
        live       = mask & before_hit;
        count      = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(live[i]);
        end
    end
endmodule

// File: rtl/mask_zero_counter.sv
module mask_zero_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_src,
    input  logic [W-1:0] in_mask,
    input  logic         in_lead,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    import mzc_pkg::*;

    localparam int unsigned CW = count_width(W);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } state_t;

    state_t       st_d, st_q;
    scan_dir_e    dir;
    logic [W-1:0] src_n;
    logic [W-1:0] mask_n;
    logic [CW-1:0] cnt;

    assign dir = in_lead ? SCAN_DOWN : SCAN_UP;

    mzc_orient #(.W(W)) orient_i (
        .dir    (dir),
        .src_i  (in_src),
        .mask_i (in_mask),
        .src_o  (src_n),
        .mask_o (mask_n)
    );

    mzc_scan #(.W(W), .CW(CW)) scan_i (
        .src   (src_n),
        .mask  (mask_n),
        .count (cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = {{(W-CW){1'b0}}, cnt};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/mzc_checker.sv
module mzc_checker #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_src,
    input logic [W-1:0] in_mask,
    input logic         in_lead,
    input logic         out_valid,
    input logic [W-1:0] out_result
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_first_up_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_lead && in_src[0] && in_mask[0]) |=> out_result == '0);

    p_first_down_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_lead && in_src[W-1] && in_mask[W-1]) |=> out_result == '0);

    p_le_mask_ones_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result <= W'($past($countones(in_mask))));

    p_zero_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask == '0) |=> out_result == '0);

    p_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        out_result <= W);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
endmodule

bind mask_zero_counter mzc_checker #(.W(W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_src     (in_src),
    .in_mask    (in_mask),
    .in_lead    (in_lead),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/mask_zero_counter_tb_top.sv
module mask_zero_counter_tb_top;
    localparam int unsigned W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_mask = '0;
    logic         in_lead = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mask_zero_counter #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_src     (in_src),
        .in_mask    (in_mask),
        .in_lead    (in_lead),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] s,
                                           input logic [W-1:0] m,
                                           input logic lead);
        int n = 0;
        for (int k = 0; k < W; k++) begin
            int idx = lead ? (W - 1 - k) : k;
            if (m[idx]) begin
                if (s[idx]) break;
                n++;
            end
        end
        return W'(n);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request, then sample at the next falling edge (one register).
    task automatic send(input logic [W-1:0] s, input logic [W-1:0] m, input logic lead);
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = s;
        in_mask  = m;
        in_lead  = lead;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic req(input string tag, input logic [W-1:0] s, input logic [W-1:0] m,
                       input logic lead, input logic [W-1:0] exp);
        send(s, m, lead);
        chk({tag, " valid"}, W'(out_valid), W'(1));
        chk(tag, out_result, exp);
        chk({tag, " model"}, out_result, model(s, m, lead));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        in_valid = 1'b1;
        in_mask = '1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", W'(out_valid), W'(0));
        chk("R1 result in reset", out_result, '0);
        in_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_mid_reset;
        req("R1 preload", '0, 64'hFF, 1'b0, 64'd8);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset result", out_result, '0);
        chk("R1 mid reset valid", W'(out_valid), W'(0));
    endtask

    task automatic t_trailing;
        req("R3 trailing bit4 stop", 64'h10, 64'hFF, 1'b0, 64'd4);
        req("R3 trailing high hit", 64'h8000_0000_0000_0000, '1, 1'b0, 64'd63);
    endtask

    task automatic t_leading;
        req("R4 leading bit59 stop", 64'h0800_0000_0000_0000, '1, 1'b1, 64'd4);
        req("R4 leading low hit", 64'h1, '1, 1'b1, 64'd63);
    endtask

    task automatic t_skip;
        req("R5 masked-out ones ignored", 64'h1AA, 64'h155, 1'b0, 64'd4);
        req("R5 masked-out ones ignored lead", 64'h5500_0000_0000_0000,
            64'hAA80_0000_0000_0000, 1'b1, 64'd5);
    endtask

    task automatic t_stop;
        req("R6 immediate stop trailing", 64'h1, 64'h1, 1'b0, 64'd0);
        req("R6 immediate stop leading", 64'h8000_0000_0000_0000, '1, 1'b1, 64'd0);
        req("R6 first of two hits", 64'h0101, 64'h0F0F, 1'b0, 64'd0);
        req("R6 later hit stops", 64'h0F00, 64'h0F0E, 1'b0, 64'd3);
    endtask

    task automatic t_no_stop;
        req("R7 no hit counts mask", '0, 64'hF0F0_F0F0_F0F0_F0F0, 1'b1, 64'd32);
        req("R7 zero mask", '0, '0, 1'b0, 64'd0);
        req("R7 ones src zero mask", '1, '0, 1'b1, 64'd0);
        req("R7 disjoint", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 64'd32);
    endtask

    task automatic t_max;
        req("R8 max trailing", '0, '1, 1'b0, 64'd64);
        req("R8 max leading", '0, '1, 1'b1, 64'd64);
    endtask

    task automatic t_hold;
        req("R9 before hold", 64'h100, 64'h1FF, 1'b0, 64'd8);
        for (int k = 0; k < 3; k++) begin
            in_src  = 64'h1 << k;
            in_mask = '1;
            in_lead = k[0];
            @(negedge clk);
            chk("R9 held result", out_result, 64'd8);
            chk("R2 valid low when idle", W'(out_valid), W'(0));
        end
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1;
        in_src = '0; in_mask = 64'h3; in_lead = 1'b0;
        @(negedge clk);
        chk("R2 b2b first", out_result, 64'd2);
        in_mask = 64'h7;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second", out_result, 64'd3);
        chk("R2 b2b valid", W'(out_valid), W'(1));
        @(negedge clk);
        chk("R2 b2b valid drop", W'(out_valid), W'(0));
    endtask

    task automatic t_sweep;
        logic [W-1:0] lfsr = 64'hACE1_1234_5678_9ABD;
        for (int k = 0; k < 120; k++) begin
            logic [W-1:0] s, m;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            s = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            m = lfsr;
            if (k % 3 == 1) s = s & {lfsr[31:0], lfsr[63:32]} & (lfsr >> 5);
            if (k % 3 == 2) m = m & (lfsr << 7) & ~s;
            send(s, m, k[0]);
            chk(k[0] ? "R4 sweep" : "R3 sweep", out_result, model(s, m, k[0]));
        end
    endtask

    initial begin
        t_reset();
        t_trailing();
        t_leading();
        t_skip();
        t_stop();
        t_no_stop();
        t_max();
        t_hold();
        t_back_to_back();
        t_mid_reset();
        t_sweep();
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule